// File: doc/BRIEF.md
# Superframe Fs-Bit Data Link Transmitter

This block places a host-supplied maintenance message into the Fs framing-bit slots of an outgoing T1 superframe. A superframe has twelve frames. The six even-numbered frames (2, 4, …, 12) each carry one Fs bit. The framer pulses a per-frame strobe and marks frame 1 with a superframe-start flag. In the cycle of an Fs strobe, the block returns the bit to be sent.

With the data link mode on, one 6-bit word is taken from storage at each superframe start. Its bits go out least significant bit first, one per Fs slot. Six superframes carry one 36-bit message, which takes about 9 ms. The words are held in two six-word buffers. One buffer is transmitted while the host fills the other through a plain write port. The buffers trade places after the last word of a message has been fetched, and the block raises a one-cycle pulse when they do. With the mode off, the Fs slots carry the normal alignment pattern instead, and the message state stays parked.

The host composes the words itself: a fixed lead word, concentrator, maintenance, alarm and line-switch fields, and fixed filler bits. The block sends whatever the selected buffer holds.

Top module: `fs_link_tx`

## Requirements
- R1: After reset, both buffers hold all-zero words, `free_buf` is 1 (buffer 0 is transmitted first), `swap_irq` is 0, and the next message starts at address 0.
- R2: While `mode_en` is 0, the six Fs slots of a superframe carry 0,0,1,1,1,0 in frame order (frames 2 to 12). No buffer swap occurs, and the word address is held at 0.
- R3: While `mode_en` is 1, the Fs slot of frame 2k (k = 1..6) carries bit k-1 of the word fetched at the start of that superframe, so bit 0 goes out first.
- R4: Successive superframes fetch the words at addresses 0,1,2,3,4,5 of the active buffer in that order, and then wrap to address 0.
- R5: The clock edge that fetches address 5 toggles the active buffer. In the following cycle `swap_irq` is 1 for exactly one cycle, and `free_buf` then names the buffer that was just drained.
- R6: A write with `wr_en`=1 stores `wr_data` at `wr_addr` (0..5) in the buffer named by `free_buf`. It does not alter the message being sent. Addresses 6 and 7 are ignored.
- R7: A write in the same cycle as the swapping fetch lands in the buffer that `free_buf` named in that cycle, which is the buffer that becomes active. That word is sent in the next message.
- R8: `fs_slot` is 1 only in a strobe cycle of an even frame. `fs_bit` is 0 whenever `fs_slot` is 0.
- R9: A strobe with `sf_start`=1 restarts the frame count at frame 1, whatever the previous count was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | 1: Fs slots carry the data link; 0: alignment pattern |
| frm_stb | input | 1 | One-cycle strobe per frame |
| sf_start | input | 1 | Marks the strobe of frame 1 of a superframe |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 3 | Host word address (0..5 valid) |
| wr_data | input | 6 | Host word data |
| fs_bit | output | 1 | Fs bit value for the current strobe |
| fs_slot | output | 1 | Current strobe is an Fs frame |
| free_buf | output | 1 | Index of the buffer the host may write |
| swap_irq | output | 1 | One-cycle pulse on a buffer swap |

## Verification
A host write and the buffer swap can fall in the same clock edge: the write is aimed at the free buffer while the fetch of address 5 hands that same buffer over to transmission. The bench provokes this by driving a write to address 0 in the frame-1 strobe cycle of the sixth superframe of a message. It then judges the outcome on the line. The next message must open with the newly written word, and its other five words must still come from the earlier fill. `free_buf` must also flip in the expected direction.

// File: rtl/fs_link_tx.sv
module fs_link_tx #(
  parameter int WORD_W    = 6,
  parameter int NUM_WORDS = 6,
  parameter logic [WORD_W-1:0] ALIGN_PAT = 6'b011100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              frm_stb,
  input  logic              sf_start,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              fs_bit,
  output logic              fs_slot,
  output logic              free_buf,
  output logic              swap_irq
);

  localparam int SF_FRAMES = 2 * WORD_W;
  localparam int FRM_W     = $clog2(SF_FRAMES + 1);
  localparam int IDX_W     = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [2][NUM_WORDS];
  logic              act;
  logic [2:0]        widx;
  logic [FRM_W-1:0]  frame_q, cur_frame;
  logic [WORD_W-1:0] sh;
  logic [IDX_W-1:0]  pidx;

  wire stb_sf   = frm_stb & sf_start;
  wire last     = (widx == 3'(NUM_WORDS - 1));
  wire wr_ok    = wr_en && (wr_addr < 3'(NUM_WORDS));

  always_comb begin
    if (sf_start || frame_q == FRM_W'(SF_FRAMES)) cur_frame = FRM_W'(1);
    else                                         cur_frame = frame_q + FRM_W'(1);
  end

  assign pidx     = IDX_W'(cur_frame[FRM_W-1:1] - 1'b1);
  assign fs_slot  = frm_stb && !cur_frame[0];
  assign fs_bit   = fs_slot && (mode_en ? sh[0] : ALIGN_PAT[pidx]);
  assign free_buf = ~act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      widx     <= '0;
      frame_q  <= FRM_W'(SF_FRAMES);
      sh       <= '0;
      swap_irq <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < NUM_WORDS; w++)
          mem[b][w] <= '0;
    end else begin
      swap_irq <= 1'b0;
      if (frm_stb) frame_q <= cur_frame;
      if (!mode_en) widx <= '0;
      if (stb_sf && mode_en) begin
        sh   <= mem[act][widx];
        widx <= last ? '0 : widx + 3'd1;
        if (last) begin
          act      <= ~act;
          swap_irq <= 1'b1;
        end
      end else if (fs_slot && mode_en) begin
        sh <= sh >> 1;
      end
      if (wr_ok) mem[~act][wr_addr] <= wr_data;
    end
  end

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    swap_irq |=> !swap_irq);
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    swap_irq |-> $past(stb_sf && mode_en && last));
  a_r5_free_flips: assert property (@(posedge clk) disable iff (!rst_n)
    swap_irq |-> (free_buf != $past(free_buf)));
  a_r2_no_swap_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !swap_irq);
  a_r8_slot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fs_slot |-> frm_stb);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_slot |-> !fs_bit);
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    widx < 3'(NUM_WORDS));

endmodule

// File: tb/test_fs_link_tx.sv
module test_fs_link_tx;
  logic clk = 0, rst_n = 0, mode_en = 0, frm_stb = 0, sf_start = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic fs_bit, fs_slot, free_buf, swap_irq;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  logic [5:0] msg_a [6] = '{6'b011100, 6'b111100, 6'b101011, 6'b100110, 6'b110100, 6'b011010};
  logic [5:0] msg_b [6] = '{6'b011100, 6'b011100, 6'b010101, 6'b101001, 6'b001010, 6'b010101};

  fs_link_tx i_fs_link_tx (.clk, .rst_n, .mode_en, .frm_stb, .sf_start, .wr_en,
    .wr_addr, .wr_data, .fs_bit, .fs_slot, .free_buf, .swap_irq);

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n && swap_irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic host_wr(input logic [2:0] a, input logic [5:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic superframe(input int nfr, input bit do_wr, input logic [2:0] a,
                            input logic [5:0] d, output logic [5:0] word);
    int slots = 0;
    word = '0;
    for (int f = 1; f <= nfr; f++) begin
      @(negedge clk);
      frm_stb = 1; sf_start = (f == 1);
      if (f == 1 && do_wr) begin wr_en = 1; wr_addr = a; wr_data = d; end
      #1;
      chk($sformatf("R8 slot frame %0d", f), fs_slot, (f % 2 == 0));
      if (fs_slot) begin word[slots] = fs_bit; slots++; end
      else chk("R8 quiet bit", fs_bit, 0);
      @(negedge clk);
      frm_stb = 0; sf_start = 0; wr_en = 0;
    end
  endtask

  task automatic t_reset;
    chk("R1 free_buf", free_buf, 1);
    chk("R1 swap_irq", swap_irq, 0);
    chk("R1 fs_slot", fs_slot, 0);
    chk("R1 fs_bit", fs_bit, 0);
  endtask

  task automatic t_disabled;
    logic [5:0] w;
    superframe(5, 0, 0, 0, w);
    superframe(12, 0, 0, 0, w);
    chk("R9 resync pattern", w, 6'b011100);
    for (int s = 0; s < 6; s++) begin
      superframe(12, 0, 0, 0, w);
      chk("R2 align pattern", w, 6'b011100);
    end
    chk("R2 no swap", irq_cnt, 0);
    chk("R2 free_buf held", free_buf, 1);
  endtask

  task automatic t_message;
    logic [5:0] w;
    for (int k = 0; k < 6; k++) host_wr(3'(k), msg_a[k]);
    host_wr(3'd6, 6'h3F);
    host_wr(3'd7, 6'h3F);
    @(negedge clk); mode_en = 1;
    for (int s = 0; s < 6; s++) begin
      superframe(12, 0, 0, 0, w);
      chk($sformatf("R1 zero buffer word %0d", s), w, 0);
    end
    chk("R5 irq count", irq_cnt, 1);
    chk("R5 free_buf", free_buf, 0);
    for (int k = 0; k < 6; k++) host_wr(3'(k), msg_b[k]);
    for (int s = 0; s < 6; s++) begin
      superframe(12, 0, 0, 0, w);
      chk($sformatf("R3 R4 R6 word %0d", s), w, msg_a[s]);
    end
    chk("R5 irq count 2", irq_cnt, 2);
    chk("R5 free_buf back", free_buf, 1);
  endtask

  task automatic t_collide;
    logic [5:0] w;
    for (int s = 0; s < 5; s++) begin
      superframe(12, 0, 0, 0, w);
      chk($sformatf("R4 word B%0d", s), w, msg_b[s]);
    end
    chk("R7 free_buf before", free_buf, 1);
    superframe(12, 1, 3'd0, 6'b101010, w);
    chk("R7 last word", w, msg_b[5]);
    chk("R7 free_buf after", free_buf, 0);
    for (int s = 0; s < 6; s++) begin
      superframe(12, 0, 0, 0, w);
      chk($sformatf("R7 word %0d", s), w, (s == 0) ? 6'b101010 : msg_a[s]);
    end
    chk("R5 irq count 4", irq_cnt, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_message();
    t_collide();
    summary();
  end
endmodule